// File: doc/BRIEF.md
# Bank Activate and Precharge Spacing Tracker

This block follows the row commands issued to one DRAM rank and keeps, for every bank, the earliest cycle at which that bank may next receive an activate, a precharge, a read or a write. A scheduler reports each accepted activate or precharge with its bank index and the cycle on which it goes out. The block then updates the per-bank limits and the rank-wide earliest activate allowed by the rolling activate window. The scheduler compares its candidate commands against these outputs.

The rank runs in one of two organisations. In grouped mode there are 16 banks in 4 groups of 4, and bank b belongs to group b/4 (index bits [3:2]). Activates between banks of the same group are spaced by a longer delay than activates between groups. In flat mode only banks 0 to 7 exist, there are no groups, and the short activate spacing applies everywhere. All delays are configuration inputs in clock cycles, and all times are 32-bit cycle numbers that wrap modulo 2^32.

Top module: `act_spacing_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every per-bank time and the rank earliest activate read 0, both flags are low, and every bank is closed.
- R2: An accepted activate to bank b at cycle t opens b. On the next cycle b's earliest precharge equals t+tRAS, and its earliest read and earliest write each equal the larger of their old value and t+tRCD.
- R3: An accepted activate at cycle t raises the earliest activate of every bank to at least t+tRRD_L when that bank is in the same group as the activated bank (grouped mode). Banks in other groups are raised to at least t+tRRD. A value is never lowered.
- R4: In flat mode (bg_mode=0) every bank uses t+tRRD. A command to bank 8 to 15 is rejected as an error.
- R5: The block records the times of the last 4 accepted activates. Once 4 are recorded, the rank earliest activate equals the oldest recorded time plus tXAW. Before that it is 0.
- R6: An accepted activate whose cycle is below the rank earliest activate, with 4 times recorded, raises xaw_viol for one cycle. The activate is still recorded and still applied.
- R7: An accepted explicit precharge (pre_auto=0) to bank b at cycle t closes b and raises b's earliest activate to at least t+tRP. It also raises every bank's earliest precharge to at least t+tPPD.
- R8: An accepted automatic precharge (pre_auto=1) closes b, applies the same tRP rule, and overwrites b's earliest precharge with t. No other bank's earliest precharge changes.
- R9: An activate to an open bank, a precharge to a closed bank, or a command to a bank outside the mode's range raises cmd_err for one cycle. That command changes no state.
- R10: When an activate and a precharge arrive on the same cycle, only the activate is considered. The precharge is dropped, changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bg_mode | input | 1 | 1 = 16 banks in 4 groups, 0 = 8 flat banks |
| cfg_trcd | input | 32 | Activate-to-column delay, cycles |
| cfg_tras | input | 32 | Activate-to-precharge delay, cycles |
| cfg_trrd | input | 32 | Activate spacing, different group or flat mode |
| cfg_trrd_l | input | 32 | Activate spacing, same group |
| cfg_trp | input | 32 | Precharge-to-activate delay, cycles |
| cfg_tppd | input | 32 | Explicit precharge-to-precharge delay, cycles |
| cfg_txaw | input | 32 | Length of the four-activate window, cycles |
| act_valid | input | 1 | Activate event present |
| act_bank | input | 4 | Activate bank index |
| act_time | input | 32 | Activate issue cycle |
| pre_valid | input | 1 | Precharge event present |
| pre_bank | input | 4 | Precharge bank index |
| pre_auto | input | 1 | 1 = automatic or precharge-all, 0 = explicit |
| pre_time | input | 32 | Precharge issue cycle |
| bank_act_at | output | 512 | Earliest activate per bank, bank j at [32j+31:32j] |
| bank_pre_at | output | 512 | Earliest precharge per bank |
| bank_rd_at | output | 512 | Earliest read per bank |
| bank_wr_at | output | 512 | Earliest write per bank |
| rank_act_at | output | 32 | Rank earliest activate from the activate window |
| xaw_viol | output | 1 | One-cycle pulse: activate inside the window |
| cmd_err | output | 1 | One-cycle pulse: rejected command |

## Verification
The bench targets the following design errors:
- **Group decode:** it activates banks at the boundaries of a group. A wrong group decode puts tRRD_L on a neighbour in another group.
- **Window order:** it fills the four-entry window and then sends an activate early. A design that takes the newest entry instead of the oldest shifts rank_act_at and misses the violation.
- **Precharge kinds:** it mixes explicit and automatic precharges. A design that applies tPPD on the automatic kind raises every bank's earliest precharge. A design that uses max instead of overwrite leaves a stale value on the precharged bank.
- **Rejected and colliding commands:** it sends commands to open, closed and out-of-range banks, and activates together with precharges. A design that lets these through changes timers that must stay frozen.

// File: rtl/asg_pkg.sv
package asg_pkg;

  localparam int TIME_W = 32;
  typedef logic [TIME_W-1:0] tick_t;

  typedef struct packed {
    tick_t trcd;
    tick_t tras;
    tick_t trrd;
    tick_t trrd_l;
    tick_t trp;
    tick_t tppd;
    tick_t txaw;
  } tcfg_t;

  // larger of two cycle numbers
  function automatic tick_t later_of(tick_t a, tick_t b);
    return (a > b) ? a : b;
  endfunction

  // group membership: groups are consecutive runs of per_grp banks
  function automatic logic same_group(int unsigned a, int unsigned b,
                                      int unsigned per_grp);
    return (a / per_grp) == (b / per_grp);
  endfunction

  // activate spacing a bank sees after an activate elsewhere
  function automatic tick_t act_gap(logic grouped, logic same_grp,
                                    tick_t short_gap, tick_t long_gap);
    return (grouped && same_grp) ? long_gap : short_gap;
  endfunction

endpackage

// File: rtl/asg_cmd_filter.sv
module asg_cmd_filter #(
  parameter int BANKS = 16
) (
  input  logic                     bg_mode,
  input  logic [$clog2(BANKS)-1:0] act_bank,
  input  logic                     act_valid,
  input  logic [$clog2(BANKS)-1:0] pre_bank,
  input  logic                     pre_valid,
  input  logic [BANKS-1:0]         open_mask,
  output logic                     act_take,
  output logic                     pre_take,
  output logic                     bad_cmd
);
  localparam int HALF = BANKS / 2;

  logic act_in_range;
  logic pre_in_range;
  logic pre_live;

  assign act_in_range = bg_mode || (int'(act_bank) < HALF);
  assign pre_in_range = bg_mode || (int'(pre_bank) < HALF);
  // an activate on the same cycle shadows the precharge
  assign pre_live     = pre_valid && !act_valid;
  assign act_take     = act_valid && act_in_range && !open_mask[act_bank];
  assign pre_take     = pre_live && pre_in_range && open_mask[pre_bank];
  assign bad_cmd      = (act_valid && !act_take) || (pre_live && !pre_take);

endmodule

// File: rtl/asg_act_window.sv
module asg_act_window
  import asg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  act_take,
  input  tick_t act_time,
  input  tick_t txaw,
  output tick_t rank_act_at,
  output logic  viol_o
);
  tick_t            hist_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic             viol_q;
  logic             full;
  tick_t            limit;

  assign full        = vld_q[DEPTH-1];
  assign limit       = hist_q[DEPTH-1] + txaw;
  assign rank_act_at = full ? limit : '0;
  assign viol_o      = viol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      viol_q <= 1'b0;
      for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
    end else begin
      viol_q <= act_take && full && (act_time < limit);
      if (act_take) begin
        hist_q[0] <= act_time;
        vld_q     <= {vld_q[DEPTH-2:0], 1'b1};
        for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
      end
    end
  end

  AST_NO_VIOL_BEFORE_FULL: assert property (@(posedge clk) disable iff (rst)
    !full |=> !viol_q); // R6
  AST_WINDOW_FILLS: assert property (@(posedge clk) disable iff (rst)
    (act_take && vld_q[DEPTH-2]) |=> full); // R5

endmodule

// File: rtl/asg_bank_timer.sv
module asg_bank_timer
  import asg_pkg::*;
#(
  parameter int BANKS  = 16,
  parameter int GROUPS = 4,
  parameter int IDX    = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tcfg_t                    cfg,
  input  logic                     bg_mode,
  input  logic                     act_take,
  input  logic [$clog2(BANKS)-1:0] act_bank,
  input  tick_t                    act_time,
  input  logic                     pre_take,
  input  logic [$clog2(BANKS)-1:0] pre_bank,
  input  tick_t                    pre_time,
  input  logic                     pre_auto,
  output logic                     open_o,
  output tick_t                    act_at,
  output tick_t                    pre_at,
  output tick_t                    rd_at,
  output tick_t                    wr_at
);
  localparam int BPG = BANKS / GROUPS;
  localparam int BW  = $clog2(BANKS);

  logic  open_q;
  tick_t act_q, pre_q, rd_q, wr_q;
  logic  is_act_me, is_pre_me, grp_match;
  tick_t act_floor;

  assign is_act_me = act_take && (act_bank == BW'(IDX));
  assign is_pre_me = pre_take && (pre_bank == BW'(IDX));
  assign grp_match = same_group(int'(act_bank), IDX, BPG);
  assign act_floor = act_time + act_gap(bg_mode, grp_match, cfg.trrd, cfg.trrd_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      act_q  <= '0;
      pre_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
    end else if (act_take) begin
      act_q <= later_of(act_q, act_floor);
      if (is_act_me) begin
        open_q <= 1'b1;
        pre_q  <= act_time + cfg.tras;
        rd_q   <= later_of(rd_q, act_time + cfg.trcd);
        wr_q   <= later_of(wr_q, act_time + cfg.trcd);
      end
    end else if (pre_take) begin
      if (is_pre_me) begin
        open_q <= 1'b0;
        act_q  <= later_of(act_q, pre_time + cfg.trp);
      end
      if (pre_auto) begin
        if (is_pre_me) pre_q <= pre_time;
      end else begin
        pre_q <= later_of(pre_q, pre_time + cfg.tppd);
      end
    end
  end

  assign open_o = open_q;
  assign act_at = act_q;
  assign pre_at = pre_q;
  assign rd_at  = rd_q;
  assign wr_at  = wr_q;

  AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (rst)
    is_act_me |=> open_q); // R2
  AST_RD_COVERS_RCD: assert property (@(posedge clk) disable iff (rst)
    is_act_me |=> (rd_q >= $past(act_time + cfg.trcd))); // R2
  AST_ACT_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (act_q >= $past(act_q))); // R3
  AST_CLOSE_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    is_pre_me |=> !open_q); // R7
  AST_AUTO_LEAVES_OTHERS: assert property (@(posedge clk) disable iff (rst)
    (pre_take && pre_auto && !is_pre_me) |=> $stable(pre_q)); // R8

endmodule

// File: rtl/act_spacing_guard.sv
module act_spacing_guard
  import asg_pkg::*;
#(
  parameter int BANKS     = 16,
  parameter int GROUPS    = 4,
  parameter int ACT_LIMIT = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bg_mode,
  input  logic [TIME_W-1:0]         cfg_trcd,
  input  logic [TIME_W-1:0]         cfg_tras,
  input  logic [TIME_W-1:0]         cfg_trrd,
  input  logic [TIME_W-1:0]         cfg_trrd_l,
  input  logic [TIME_W-1:0]         cfg_trp,
  input  logic [TIME_W-1:0]         cfg_tppd,
  input  logic [TIME_W-1:0]         cfg_txaw,
  input  logic                      act_valid,
  input  logic [$clog2(BANKS)-1:0]  act_bank,
  input  logic [TIME_W-1:0]         act_time,
  input  logic                      pre_valid,
  input  logic [$clog2(BANKS)-1:0]  pre_bank,
  input  logic                      pre_auto,
  input  logic [TIME_W-1:0]         pre_time,
  output logic [BANKS*TIME_W-1:0]   bank_act_at,
  output logic [BANKS*TIME_W-1:0]   bank_pre_at,
  output logic [BANKS*TIME_W-1:0]   bank_rd_at,
  output logic [BANKS*TIME_W-1:0]   bank_wr_at,
  output logic [TIME_W-1:0]         rank_act_at,
  output logic                      xaw_viol,
  output logic                      cmd_err
);
  tcfg_t            cfg;
  logic [BANKS-1:0] open_mask;
  logic             act_take, pre_take, bad_cmd;
  logic             err_q;

  assign cfg = '{trcd: cfg_trcd, tras: cfg_tras, trrd: cfg_trrd,
                 trrd_l: cfg_trrd_l, trp: cfg_trp, tppd: cfg_tppd,
                 txaw: cfg_txaw};

  asg_cmd_filter #(.BANKS(BANKS)) u_filter (
    .bg_mode  (bg_mode),
    .act_bank (act_bank),
    .act_valid(act_valid),
    .pre_bank (pre_bank),
    .pre_valid(pre_valid),
    .open_mask(open_mask),
    .act_take (act_take),
    .pre_take (pre_take),
    .bad_cmd  (bad_cmd)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    asg_bank_timer #(.BANKS(BANKS), .GROUPS(GROUPS), .IDX(g)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .cfg     (cfg),
      .bg_mode (bg_mode),
      .act_take(act_take),
      .act_bank(act_bank),
      .act_time(act_time),
      .pre_take(pre_take),
      .pre_bank(pre_bank),
      .pre_time(pre_time),
      .pre_auto(pre_auto),
      .open_o  (open_mask[g]),
      .act_at  (bank_act_at[g*TIME_W +: TIME_W]),
      .pre_at  (bank_pre_at[g*TIME_W +: TIME_W]),
      .rd_at   (bank_rd_at[g*TIME_W +: TIME_W]),
      .wr_at   (bank_wr_at[g*TIME_W +: TIME_W])
    );
  end

  asg_act_window #(.DEPTH(ACT_LIMIT)) u_window (
    .clk        (clk),
    .rst        (rst),
    .act_take   (act_take),
    .act_time   (act_time),
    .txaw       (cfg_txaw),
    .rank_act_at(rank_act_at),
    .viol_o     (xaw_viol)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad_cmd;
  end
  assign cmd_err = err_q;

  AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $countones({act_take, pre_take}) <= 1); // R10
  AST_ERR_FREEZES_OPEN: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (open_mask == $past(open_mask))); // R9
  AST_RESET_CLOSED: assert property (@(posedge clk)
    $fell(rst) |-> (open_mask == '0)); // R1

endmodule

// File: tb/act_spacing_guard_bench.sv
module act_spacing_guard_bench;
  localparam int NB = 16;
  localparam int TW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, bg_mode;
  logic [TW-1:0] cfg_trcd, cfg_tras, cfg_trrd, cfg_trrd_l, cfg_trp, cfg_tppd, cfg_txaw;
  logic act_valid, pre_valid, pre_auto;
  logic [3:0] act_bank, pre_bank;
  logic [TW-1:0] act_time, pre_time;
  logic [NB*TW-1:0] bank_act_at, bank_pre_at, bank_rd_at, bank_wr_at;
  logic [TW-1:0] rank_act_at;
  logic xaw_viol, cmd_err;

  act_spacing_guard u_act_spacing_guard (
    .clk(clk), .rst(rst), .bg_mode(bg_mode),
    .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trrd(cfg_trrd),
    .cfg_trrd_l(cfg_trrd_l), .cfg_trp(cfg_trp), .cfg_tppd(cfg_tppd),
    .cfg_txaw(cfg_txaw),
    .act_valid(act_valid), .act_bank(act_bank), .act_time(act_time),
    .pre_valid(pre_valid), .pre_bank(pre_bank), .pre_auto(pre_auto),
    .pre_time(pre_time),
    .bank_act_at(bank_act_at), .bank_pre_at(bank_pre_at),
    .bank_rd_at(bank_rd_at), .bank_wr_at(bank_wr_at),
    .rank_act_at(rank_act_at), .xaw_viol(xaw_viol), .cmd_err(cmd_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;
  int unsigned now = 100;

  // reference state
  int unsigned m_act [NB];
  int unsigned m_pre [NB];
  int unsigned m_rd  [NB];
  bit          m_open[NB];
  int unsigned m_hist[$];
  int unsigned m_rank;
  bit          m_viol, m_err;

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int unsigned mx(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(string req, string what, longint actual, longint expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  function automatic int unsigned d_act(int j); return bank_act_at[j*TW +: TW]; endfunction
  function automatic int unsigned d_pre(int j); return bank_pre_at[j*TW +: TW]; endfunction

  task automatic model_reset();
    for (int j = 0; j < NB; j++) begin
      m_act[j] = 0; m_pre[j] = 0; m_rd[j] = 0; m_open[j] = 0;
    end
    m_hist.delete();
    m_rank = 0; m_viol = 0; m_err = 0;
  endtask

  task automatic model_apply(bit av, int ab, int unsigned at,
                             bit pv, int pb, int unsigned pt, bit pa);
    int nb;
    nb = bg_mode ? 16 : 8;
    m_viol = 0; m_err = 0;
    if (av) begin
      if (ab >= nb || m_open[ab]) m_err = 1;
      else begin
        if (m_hist.size() == 4 && at < m_hist[0] + cfg_txaw) m_viol = 1;
        m_hist.push_back(at);
        if (m_hist.size() > 4) void'(m_hist.pop_front());
        for (int j = 0; j < NB; j++) begin
          int unsigned gap;
          gap = (bg_mode && (j / 4 == ab / 4)) ? cfg_trrd_l : cfg_trrd;
          m_act[j] = mx(m_act[j], at + gap);
        end
        m_open[ab] = 1;
        m_pre[ab]  = at + cfg_tras;
        m_rd[ab]   = mx(m_rd[ab], at + cfg_trcd);
      end
    end else if (pv) begin
      if (pb >= nb || !m_open[pb]) m_err = 1;
      else begin
        m_open[pb] = 0;
        m_act[pb]  = mx(m_act[pb], pt + cfg_trp);
        if (pa) m_pre[pb] = pt;
        else for (int j = 0; j < NB; j++) m_pre[j] = mx(m_pre[j], pt + cfg_tppd);
      end
    end
    m_rank = (m_hist.size() == 4) ? m_hist[0] + cfg_txaw : 0;
  endtask

  task automatic compare_all(bit at_reset);
    for (int j = 0; j < NB; j++) begin
      check(at_reset ? "R1" : "R3", $sformatf("act_at[%0d]", j), d_act(j), m_act[j]);
      check(at_reset ? "R1" : "R7", $sformatf("pre_at[%0d]", j), d_pre(j), m_pre[j]);
      check(at_reset ? "R1" : "R2", $sformatf("rd_at[%0d]", j), bank_rd_at[j*TW +: TW], m_rd[j]);
      check(at_reset ? "R1" : "R2", $sformatf("wr_at[%0d]", j), bank_wr_at[j*TW +: TW], m_rd[j]);
    end
    check(at_reset ? "R1" : "R5", "rank_act_at", rank_act_at, m_rank);
    check(at_reset ? "R1" : "R6", "xaw_viol", xaw_viol, m_viol);
    check(at_reset ? "R1" : "R9", "cmd_err", cmd_err, m_err);
  endtask

  // apply one cycle of stimulus from a negedge, compare at the next negedge
  task automatic step(bit av, int ab, int unsigned at,
                      bit pv, int pb, int unsigned pt, bit pa);
    act_valid = av; act_bank = 4'(ab); act_time = at;
    pre_valid = pv; pre_bank = 4'(pb); pre_time = pt; pre_auto = pa;
    @(negedge clk);
    model_apply(av, ab, at, pv, pb, pt, pa);
    compare_all(1'b0);
    act_valid = 0; pre_valid = 0;
  endtask

  task automatic do_reset(bit grouped);
    rst = 1; bg_mode = grouped;
    act_valid = 0; pre_valid = 0; pre_auto = 0;
    act_bank = 0; pre_bank = 0; act_time = 0; pre_time = 0;
    cfg_trcd = 12; cfg_tras = 29; cfg_trp = 12; cfg_tppd = 2;
    cfg_trrd = grouped ? 3 : 7; cfg_trrd_l = grouped ? 5 : 0;
    cfg_txaw = grouped ? 14 : 28;
    repeat (3) @(negedge clk);
    model_reset();
    compare_all(1'b1);  // R1 during reset
    rst = 0;
    @(negedge clk);
    compare_all(1'b1);  // R1 first cycle after
  endtask

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      int unsigned op, b1, b2;
      op = rnd() % 8; b1 = rnd() % 16; b2 = rnd() % 16;
      now += 3;
      case (op)
        0, 1, 2: step(1, b1, now + rnd() % 4, 0, 0, 0, 0);
        3, 4:    step(0, 0, 0, 1, b2, now + rnd() % 4, 0);
        5:       step(0, 0, 0, 1, b2, now + rnd() % 4, 1);
        6:       step(1, b1, now, 1, b2, now, rnd() % 2);
        default: step(0, 0, 0, 0, 0, 0, 0);
      endcase
    end
  endtask

  initial begin
    do_reset(1'b1);
    // group boundaries for R3
    step(1, 5, 100, 0, 0, 0, 0);
    check("R3", "same group bank4", d_act(4), 105);
    check("R3", "other group bank8", d_act(8), 103);
    step(1, 5, 110, 0, 0, 0, 0);                 // R9 open bank
    check("R9", "pre_at bank5 frozen", d_pre(5), 129);
    step(1, 0, 104, 0, 0, 0, 0);
    step(1, 8, 108, 0, 0, 0, 0);
    step(1, 12, 112, 0, 0, 0, 0);
    check("R5", "rank after four", rank_act_at, 114);
    step(1, 1, 113, 0, 0, 0, 0);
    check("R6", "early activate flagged", xaw_viol, 1);
    check("R5", "window slides", rank_act_at, 118);
    step(0, 0, 0, 1, 0, 130, 0);                 // explicit
    check("R7", "unused bank gets tPPD", d_pre(2), 132);
    step(0, 0, 0, 1, 5, 135, 1);                 // automatic
    check("R8", "auto overwrites own", d_pre(5), 135);
    check("R8", "auto leaves others", d_pre(2), 132);
    step(0, 0, 0, 1, 0, 140, 0);                 // closed bank
    check("R9", "pre to closed", cmd_err, 1);
    step(1, 2, 141, 1, 8, 141, 0);
    check("R10", "shadowed pre leaves bank8", d_pre(8), m_pre[8]);
    check("R10", "shadowed pre no error", cmd_err, 0);
    random_phase(300);

    do_reset(1'b0);
    now = 100;
    step(1, 9, 100, 0, 0, 0, 0);
    check("R4", "bank9 out of range", cmd_err, 1);
    step(1, 1, 101, 0, 0, 0, 0);
    check("R4", "flat spacing bank2", d_act(2), 108);
    check("R4", "flat spacing bank7", d_act(7), 108);
    random_phase(300);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule